// File: doc/BRIEF.md
# Atomic Read-Modify-Write Memory Unit

This block holds a small word-addressed memory and applies one indivisible read-modify-write operation to it for each request. A requester offers an opcode, a sub-opcode, a word address and two register operands (`rx`, `ry`) on a valid/ready request channel. The unit reads the addressed word, decides whether and what to write back, and writes it in the following cycle. It then presents the old word, a result value for the `ry` register, a success flag and an error flag on a valid/ready response channel.

Only one operation is in flight at any time. The request channel stays closed from the accepting edge until the response has been taken, so requests from competing masters are strictly serialized on the memory. The supported primitives are test-and-set, fetch-and-op (increment, decrement, add, subtract), exchange and compare-and-swap. Plain load and store are supported as well. All arithmetic wraps modulo 2^DATA_W.

Top module: `amo_unit`

## Requirements
- R1: `req_ready_o` is high only while the unit is idle. It drops after the edge that accepts a request and stays low until the response handshake completes. It is high again at the first sample after that handshake edge. `rsp_valid_o` rises after the second rising edge that follows the accepting edge.
- R2: While `rsp_valid_o` is high and `rsp_ready_i` is low, the response stays valid and every response field holds its value.
- R3: Opcode 0 (load) returns the word and leaves memory unchanged, with `rsp_ok_o`=0. Opcode 1 (store) writes `rx`, returns the old word and sets `rsp_ok_o`=1.
- R4: Opcode 2 (test-and-set) returns the old word. It writes `rx` only when the old word is zero, and `rsp_ok_o` is 1 exactly when that write happens.
- R5: Opcode 3 (fetch-and-op) returns the old word and writes back old+1 (sub 0), old-1 (sub 1), old+rx (sub 2) or old-rx (sub 3). The result wraps modulo 2^DATA_W, and `rsp_ok_o`=1.
- R6: Opcode 4 (exchange) writes `rx`, returns the old word and sets `rsp_ok_o`=1.
- R7: Opcode 5 (compare-and-swap) compares the old word with `rx`. On a match it writes `ry`, returns `rx` on `rsp_ry_o` and sets `rsp_ok_o`=1. On a mismatch it writes nothing, returns the old word on `rsp_ry_o` and sets `rsp_ok_o`=0.
- R8: Opcodes 6 and 7 set `rsp_err_o`=1 and `rsp_ok_o`=0, return the addressed word and leave memory unchanged. Every other opcode gives `rsp_err_o`=0.
- R9: Reset clears every memory word to zero, raises `req_ready_o` and lowers `rsp_valid_o`.
- R10: For every opcode other than 5, `rsp_ry_o` returns the `ry` operand unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request offered |
| req_ready_o | output | 1 | Unit idle, request accepted on this edge |
| req_op_i | input | 3 | Opcode |
| req_sub_i | input | 2 | Fetch-and-op selector |
| req_addr_i | input | ADDR_W | Word address |
| req_rx_i | input | DATA_W | First register operand |
| req_ry_i | input | DATA_W | Second register operand |
| rsp_valid_o | output | 1 | Response present |
| rsp_ready_i | input | 1 | Response taken |
| rsp_old_o | output | DATA_W | Word value before the operation |
| rsp_ry_o | output | DATA_W | Result for the second register |
| rsp_ok_o | output | 1 | A write took place |
| rsp_err_o | output | 1 | Unknown opcode |

## Verification
The bench builds the unit with DATA_W=8 and ADDR_W=3. With 8-bit words, the wrap of increment past 0xFF, of decrement below zero and of add and subtract can be reached with a handful of small operands. With eight words, separate addresses can be set aside for each primitive, and the top address can be used to confirm the reset value. Response holding, the closed request channel while busy, and the return to all-zero memory after a second reset are driven as directed cases after the vector walk.

// File: rtl/amo_pkg.sv
package amo_pkg;
  typedef enum logic [2:0] {
    OP_LOAD  = 3'd0,
    OP_STORE = 3'd1,
    OP_TAS   = 3'd2,
    OP_FOP   = 3'd3,
    OP_SWAP  = 3'd4,
    OP_CAS   = 3'd5,
    OP_RSV6  = 3'd6,
    OP_RSV7  = 3'd7
  } amo_op_e;

  typedef enum logic [1:0] {
    FOP_INC = 2'd0,
    FOP_DEC = 2'd1,
    FOP_ADD = 2'd2,
    FOP_SUB = 2'd3
  } fop_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD   = 2'd1,
    ST_WR   = 2'd2,
    ST_RSP  = 2'd3
  } amo_st_e;
endpackage

// File: rtl/amo_alu.sv
module amo_alu
  import amo_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  amo_op_e           op_i,
  input  fop_e              sub_i,
  input  logic [DATA_W-1:0] old_i,
  input  logic [DATA_W-1:0] rx_i,
  input  logic [DATA_W-1:0] ry_i,
  output logic              wr_en_o,
  output logic [DATA_W-1:0] new_o,
  output logic [DATA_W-1:0] ry_res_o,
  output logic              ok_o,
  output logic              err_o
);
  localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

  always_comb begin
    wr_en_o  = 1'b0;
    new_o    = old_i;
    ry_res_o = ry_i;
    err_o    = 1'b0;
    unique case (op_i)
      OP_LOAD: ;
      OP_STORE: begin
        wr_en_o = 1'b1;
        new_o   = rx_i;
      end
      OP_TAS: begin
        if (old_i == '0) begin
          wr_en_o = 1'b1;
          new_o   = rx_i;
        end
      end
      OP_FOP: begin
        wr_en_o = 1'b1;
        unique case (sub_i)
          FOP_INC: new_o = old_i + ONE;
          FOP_DEC: new_o = old_i - ONE;
          FOP_ADD: new_o = old_i + rx_i;
          FOP_SUB: new_o = old_i - rx_i;
          default: new_o = old_i;
        endcase
      end
      OP_SWAP: begin
        wr_en_o = 1'b1;
        new_o   = rx_i;
      end
      OP_CAS: begin
        if (old_i == rx_i) begin
          wr_en_o  = 1'b1;
          new_o    = ry_i;
          ry_res_o = rx_i;
        end else begin
          ry_res_o = old_i;
        end
      end
      default: err_o = 1'b1;
    endcase
    ok_o = wr_en_o;
  end
endmodule

// File: rtl/amo_mem.sv
module amo_mem #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                 mem_q[g] <= '0;
      else if (we_i && wr_addr_i == ADDR_W'(g))    mem_q[g] <= wr_data_i;
    end
  end

  assign rd_data_o = mem_q[rd_addr_i];
endmodule

// File: rtl/amo_ctrl.sv
module amo_ctrl
  import amo_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_valid_i,
  input  logic rsp_ready_i,
  output logic req_ready_o,
  output logic accept_o,
  output logic rd_slot_o,
  output logic wr_slot_o,
  output logic rsp_valid_o
);
  amo_st_e st_q, st_d;

  assign req_ready_o = (st_q == ST_IDLE);
  assign accept_o    = req_ready_o && req_valid_i;
  assign rd_slot_o   = (st_q == ST_RD);
  assign wr_slot_o   = (st_q == ST_WR);
  assign rsp_valid_o = (st_q == ST_RSP);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (req_valid_i) st_d = ST_RD;
      ST_RD:   st_d = ST_WR;
      ST_WR:   st_d = ST_RSP;
      ST_RSP:  if (rsp_ready_i) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end

  a_r1_busy_after_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o |=> !req_ready_o);
  a_r1_free_after_rsp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_ready_i) |=> req_ready_o);
  a_r1_rsp_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_slot_o |=> ##1 rsp_valid_o);
endmodule

// File: rtl/amo_unit.sv
module amo_unit
  import amo_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [2:0]        req_op_i,
  input  logic [1:0]        req_sub_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_rx_i,
  input  logic [DATA_W-1:0] req_ry_i,
  output logic              rsp_valid_o,
  input  logic              rsp_ready_i,
  output logic [DATA_W-1:0] rsp_old_o,
  output logic [DATA_W-1:0] rsp_ry_o,
  output logic              rsp_ok_o,
  output logic              rsp_err_o
);
  logic accept, rd_slot, wr_slot;

  amo_op_e           op_q;
  fop_e              sub_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] rx_q, ry_q, old_q, rd_data;

  logic              alu_we, alu_ok, alu_err;
  logic [DATA_W-1:0] alu_new, alu_ry;
  logic              mem_we;

  amo_ctrl u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .rsp_ready_i (rsp_ready_i),
    .req_ready_o (req_ready_o),
    .accept_o    (accept),
    .rd_slot_o   (rd_slot),
    .wr_slot_o   (wr_slot),
    .rsp_valid_o (rsp_valid_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q   <= OP_LOAD;
      sub_q  <= FOP_INC;
      addr_q <= '0;
      rx_q   <= '0;
      ry_q   <= '0;
    end else if (accept) begin
      op_q   <= amo_op_e'(req_op_i);
      sub_q  <= fop_e'(req_sub_i);
      addr_q <= req_addr_i;
      rx_q   <= req_rx_i;
      ry_q   <= req_ry_i;
    end
  end

  // read slot: capture the word; write slot uses only this copy
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      old_q <= '0;
    else if (rd_slot) old_q <= rd_data;
  end

  amo_alu #(.DATA_W(DATA_W)) u_alu (
    .op_i     (op_q),
    .sub_i    (sub_q),
    .old_i    (old_q),
    .rx_i     (rx_q),
    .ry_i     (ry_q),
    .wr_en_o  (alu_we),
    .new_o    (alu_new),
    .ry_res_o (alu_ry),
    .ok_o     (alu_ok),
    .err_o    (alu_err)
  );

  assign mem_we = wr_slot && alu_we;

  amo_mem #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mem (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rd_addr_i (addr_q),
    .rd_data_o (rd_data),
    .we_i      (mem_we),
    .wr_addr_i (addr_q),
    .wr_data_i (alu_new)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_old_o <= '0;
      rsp_ry_o  <= '0;
      rsp_ok_o  <= 1'b0;
      rsp_err_o <= 1'b0;
    end else if (wr_slot) begin
      rsp_old_o <= old_q;
      rsp_ry_o  <= alu_ry;
      rsp_ok_o  <= alu_ok;
      rsp_err_o <= alu_err;
    end
  end

  a_r2_rsp_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !rsp_ready_i) |=> rsp_valid_o && $stable(rsp_old_o) &&
      $stable(rsp_ry_o) && $stable(rsp_ok_o) && $stable(rsp_err_o));
  a_r8_err_no_ok: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_err_o) |-> !rsp_ok_o);
  a_r1_write_after_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we |-> $past(rd_slot));
  a_r8_no_write_on_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_slot && alu_err) |-> !mem_we);
endmodule

// File: tb/amo_unit_tb_top.sv
`timescale 1ns/1ps
module amo_unit_tb_top;
  localparam int DW = 8;
  localparam int AW = 3;
  localparam int NV = 23;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0, req_ready;
  logic [2:0]    req_op = '0;
  logic [1:0]    req_sub = '0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_rx = '0, req_ry = '0;
  logic          rsp_valid, rsp_ready = 1'b0;
  logic [DW-1:0] rsp_old, rsp_ry;
  logic          rsp_ok, rsp_err;

  int tests = 0;
  int fails = 0;

  always #10 clk = ~clk;

  amo_unit #(.DATA_W(DW), .ADDR_W(AW)) dut_i (
    .clk_i (clk), .rst_ni (rst_n),
    .req_valid_i (req_valid), .req_ready_o (req_ready),
    .req_op_i (req_op), .req_sub_i (req_sub), .req_addr_i (req_addr),
    .req_rx_i (req_rx), .req_ry_i (req_ry),
    .rsp_valid_o (rsp_valid), .rsp_ready_i (rsp_ready),
    .rsp_old_o (rsp_old), .rsp_ry_o (rsp_ry),
    .rsp_ok_o (rsp_ok), .rsp_err_o (rsp_err)
  );

  // {op, sub, addr, rx, ry, exp_old, exp_ry, exp_ok, exp_err}
  localparam logic [41:0] VEC [NV] = '{
    {3'd0, 2'd0, 3'd0, 8'h00, 8'h00, 8'h00, 8'h00, 1'b0, 1'b0}, // R3 load zero
    {3'd1, 2'd0, 3'd0, 8'h5A, 8'h11, 8'h00, 8'h11, 1'b1, 1'b0}, // R3 store, R10
    {3'd0, 2'd0, 3'd0, 8'h00, 8'h22, 8'h5A, 8'h22, 1'b0, 1'b0}, // R3 load back
    {3'd2, 2'd0, 3'd1, 8'h01, 8'h33, 8'h00, 8'h33, 1'b1, 1'b0}, // R4 tas wins
    {3'd2, 2'd0, 3'd1, 8'h07, 8'h00, 8'h01, 8'h00, 1'b0, 1'b0}, // R4 tas loses
    {3'd3, 2'd0, 3'd2, 8'h00, 8'h00, 8'h00, 8'h00, 1'b1, 1'b0}, // R5 inc
    {3'd3, 2'd1, 3'd2, 8'h00, 8'h00, 8'h01, 8'h00, 1'b1, 1'b0}, // R5 dec
    {3'd3, 2'd1, 3'd2, 8'h00, 8'h00, 8'h00, 8'h00, 1'b1, 1'b0}, // R5 dec wraps
    {3'd3, 2'd0, 3'd2, 8'h00, 8'h44, 8'hFF, 8'h44, 1'b1, 1'b0}, // R5 inc wraps
    {3'd3, 2'd2, 3'd3, 8'hF0, 8'h00, 8'h00, 8'h00, 1'b1, 1'b0}, // R5 add
    {3'd3, 2'd2, 3'd3, 8'h20, 8'h00, 8'hF0, 8'h00, 1'b1, 1'b0}, // R5 add wraps
    {3'd3, 2'd3, 3'd3, 8'h30, 8'h00, 8'h10, 8'h00, 1'b1, 1'b0}, // R5 sub wraps
    {3'd0, 2'd0, 3'd3, 8'h00, 8'h00, 8'hE0, 8'h00, 1'b0, 1'b0}, // R5 result
    {3'd4, 2'd0, 3'd4, 8'hAB, 8'h00, 8'h00, 8'h00, 1'b1, 1'b0}, // R6 swap
    {3'd4, 2'd0, 3'd4, 8'hCD, 8'h66, 8'hAB, 8'h66, 1'b1, 1'b0}, // R6 swap again
    {3'd5, 2'd0, 3'd4, 8'hCD, 8'h99, 8'hCD, 8'hCD, 1'b1, 1'b0}, // R7 cas match
    {3'd5, 2'd0, 3'd4, 8'hCD, 8'h77, 8'h99, 8'h99, 1'b0, 1'b0}, // R7 cas miss
    {3'd0, 2'd0, 3'd4, 8'h00, 8'h00, 8'h99, 8'h00, 1'b0, 1'b0}, // R7 result
    {3'd6, 2'd0, 3'd4, 8'h55, 8'h00, 8'h99, 8'h00, 1'b0, 1'b1}, // R8 op6
    {3'd7, 2'd3, 3'd0, 8'h12, 8'h00, 8'h5A, 8'h00, 1'b0, 1'b1}, // R8 op7
    {3'd0, 2'd0, 3'd4, 8'h00, 8'h00, 8'h99, 8'h00, 1'b0, 1'b0}, // R8 untouched
    {3'd0, 2'd0, 3'd0, 8'h00, 8'h00, 8'h5A, 8'h00, 1'b0, 1'b0}, // R8 untouched
    {3'd0, 2'd0, 3'd7, 8'h00, 8'h00, 8'h00, 8'h00, 1'b0, 1'b0}  // R9 top word
  };

  task automatic check(input bit cond, input string req, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
    tests++;
    if (!cond) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // returns response fields; hold = cycles the response is left waiting
  task automatic run_op(input logic [2:0] op, input logic [1:0] sub,
                        input logic [AW-1:0] addr, input logic [DW-1:0] rx,
                        input logic [DW-1:0] ry, input int hold,
                        output logic [DW-1:0] old_o, output logic [DW-1:0] ry_o,
                        output logic ok_o, output logic err_o, output int lat);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_op = op; req_sub = sub; req_addr = addr;
    req_rx = rx; req_ry = ry;
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1;
    while (!rsp_valid) begin
      check(!req_ready, "R1", "ready while busy", {7'd0, req_ready}, 8'd0);
      @(negedge clk);
      lat++;
    end
    old_o = rsp_old; ry_o = rsp_ry; ok_o = rsp_ok; err_o = rsp_err;
    for (int h = 0; h < hold; h++) begin
      check(!req_ready, "R1", "ready while held", {7'd0, req_ready}, 8'd0);
      @(negedge clk);
      check(rsp_valid && rsp_old == old_o && rsp_ry == ry_o &&
            rsp_ok == ok_o && rsp_err == err_o, "R2", "held response",
            rsp_old, old_o);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    check(req_ready && !rsp_valid, "R1", "ready after handshake",
          {7'd0, req_ready}, 8'd1);
  endtask

  initial begin
    #(20ns * 100000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests + 1, fails);
    $finish;
  end

  initial begin
    logic [DW-1:0] o, r;
    logic k, e;
    int lat;
    repeat (3) @(negedge clk);
    check(req_ready && !rsp_valid, "R9", "reset handshake", {7'd0, req_ready}, 8'd1);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready && !rsp_valid, "R9", "idle after reset", {7'd0, rsp_valid}, 8'd0);

    for (int i = 0; i < NV; i++) begin
      run_op(VEC[i][41:39], VEC[i][38:37], VEC[i][36:34], VEC[i][33:26],
             VEC[i][25:18], 0, o, r, k, e, lat);
      check(o == VEC[i][17:10], "R3-R9 vec", $sformatf("old #%0d", i), o, VEC[i][17:10]);
      check(r == VEC[i][9:2], "R7/R10 vec", $sformatf("ry #%0d", i), r, VEC[i][9:2]);
      check(k == VEC[i][1], "R4/R7 vec", $sformatf("ok #%0d", i), {7'd0, k}, {7'd0, VEC[i][1]});
      check(e == VEC[i][0], "R8 vec", $sformatf("err #%0d", i), {7'd0, e}, {7'd0, VEC[i][0]});
      check(lat == 3, "R1", $sformatf("latency #%0d", i), 8'(lat), 8'd3);
    end

    // R2: response held for several cycles while rsp_ready is low
    run_op(3'd3, 2'd2, 3'd5, 8'h07, 8'h21, 5, o, r, k, e, lat);
    check(o == 8'h00 && k, "R2", "held fop old", o, 8'h00);
    run_op(3'd0, 2'd0, 3'd5, 8'h00, 8'h00, 0, o, r, k, e, lat);
    check(o == 8'h07, "R5", "add after hold", o, 8'h07);

    // R1: request held valid across busy period is taken only once
    @(negedge clk);
    req_valid = 1'b1; req_op = 3'd3; req_sub = 2'd0; req_addr = 3'd6;
    req_rx = '0; req_ry = '0;
    @(negedge clk);
    repeat (2) @(negedge clk);
    check(rsp_valid && !req_ready, "R1", "single accept", rsp_old, 8'h00);
    req_valid = 1'b0;
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    run_op(3'd0, 2'd0, 3'd6, 8'h00, 8'h00, 0, o, r, k, e, lat);
    check(o == 8'h01, "R1", "one increment only", o, 8'h01);

    // R9: second reset clears memory
    rst_n = 1'b0;
    @(negedge clk);
    check(req_ready && !rsp_valid, "R9", "mid-run reset", {7'd0, rsp_valid}, 8'd0);
    rst_n = 1'b1;
    run_op(3'd0, 2'd0, 3'd0, 8'h00, 8'h00, 0, o, r, k, e, lat);
    check(o == 8'h00, "R9", "word 0 cleared", o, 8'h00);
    run_op(3'd0, 2'd0, 3'd4, 8'h00, 8'h00, 0, o, r, k, e, lat);
    check(o == 8'h00, "R9", "word 4 cleared", o, 8'h00);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule